// File: doc/BRIEF.md
# Free-Running Timer with Output Compare

This block is a 16-bit up-counter driven through a divide-by-four prescaler. It has one output compare channel and is programmed over a small 8-bit register bus. Software loads a 16-bit target and chooses an output level. When the counter reaches the target, the block latches that level onto the compare pin and sets a match flag. If interrupts are enabled, it also requests an interrupt. Repeated reprogramming of the target and level after each match produces output waveforms or timed events.

The target is split into an upper and a lower byte. Writing the upper byte pauses comparison until the lower byte follows, so a half-written target can never fire. The match flag is cleared by a two-step sequence: read the status register while the flag is set, then write the lower target byte. The flag and the target are not touched by reset, so software must reinitialise them with that same sequence.

Each bus access lasts one clock, with separate read and write strobes. Read data is combinational from the address.

Top module: `ocmp_timer`

## Requirements
- R1: The counter resets to 16'hFFFC and advances by exactly one every four clocks. Its upper byte reads at address 4 and its lower byte at address 5.
- R2: The compare runs once per counter value, in the clock after the counter takes that value. On a match, status bit 6 (address 1) becomes 1 and `cmp_out` takes the level bit, both visible after that clock edge.
- R3: Every match copies control bit 0 (address 0) to `cmp_out`, even when the flag is already set.
- R4: `irq` is high exactly when the flag is set and control bit 6 is 1. A match with bit 6 at 0 sets the flag but leaves `irq` low.
- R5: A write to the upper target byte (address 2) suspends all matches until the lower target byte (address 3) is written. That lower-byte write resumes comparison.
- R6: Writing only the lower target byte does not suspend comparison.
- R7: A write to the lower target byte clears the flag, and with it `irq`, only if a status read found the flag set since the last lower-byte write. Without that read, the write leaves the flag set.
- R8: Reset leaves the flag and both target bytes unchanged. It clears the control bits and drives `cmp_out` low.
- R9: If a clearing write and a match fall on the same clock, the flag stays set.
- R10: A counter value produces at most one match, even though the counter holds that value for four clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 3 | Register address |
| wr_en | input | 1 | Write strobe, one clock per access |
| rd_en | input | 1 | Read strobe, one clock per access |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational, zero when not reading |
| cmp_out | output | 1 | Compare output latch |
| irq | output | 1 | Compare interrupt request |

## Verification
After reset is released on a falling edge, the counter changes on rising edges 4, 8, 12 and so on. It reaches zero on edge 16, and a zero target therefore matches on edge 17. The bench counts rising edges from reset and samples on the falling edges before and after edge 17. Register writes and status reads take effect on the rising edge inside their own access, so register reads are checked on the next falling edge. Checks that depend only on a target being reached wait a fixed 24 to 30 clocks, which covers up to four counter steps plus the one-clock compare delay. The same-cycle collision is timed so that the clearing write lands exactly on edge 17.

// File: rtl/ocmp_timer.sv
module ocmp_timer #(
  parameter int          PRE_W    = 2,
  parameter logic [15:0] CNT_INIT = 16'hFFFC
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] addr,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       cmp_out,
  output logic       irq
);
  localparam logic [2:0] A_CTL = 3'd0, A_STS = 3'd1, A_CMH = 3'd2,
                         A_CML = 3'd3, A_CNH = 3'd4, A_CNL = 3'd5;

  logic [PRE_W-1:0] pre;
  logic [15:0]      cnt, ocr;
  logic             stb, cmp_en, flag, armed, ie, lvl;

  wire tick   = &pre;
  wire wr_ctl = wr_en && addr == A_CTL;
  wire wr_cmh = wr_en && addr == A_CMH;
  wire wr_cml = wr_en && addr == A_CML;
  wire rd_sts = rd_en && addr == A_STS;
  wire match  = stb && cmp_en && cnt == ocr;

  assign irq = flag & ie;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre     <= '0;
      cnt     <= CNT_INIT;
      stb     <= 1'b0;
      ie      <= 1'b0;
      lvl     <= 1'b0;
      cmp_out <= 1'b0;
      cmp_en  <= 1'b1;
      armed   <= 1'b0;
    end else begin
      pre <= pre + PRE_W'(1);
      stb <= tick;
      if (tick) cnt <= cnt + 16'd1;
      if (wr_ctl) begin
        ie  <= wdata[6];
        lvl <= wdata[0];
      end
      if (match) cmp_out <= lvl;
      if (wr_cmh)      cmp_en <= 1'b0;
      else if (wr_cml) cmp_en <= 1'b1;
      if (wr_cml)               armed <= 1'b0;
      else if (rd_sts && flag)  armed <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_cmh) ocr[15:8] <= wdata;
    if (wr_cml) ocr[7:0]  <= wdata;
    if (match)                flag <= 1'b1;
    else if (wr_cml && armed) flag <= 1'b0;
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (addr)
        A_CTL:   rdata = {1'b0, ie, 5'b0, lvl};
        A_STS:   rdata = {1'b0, flag, 6'b0};
        A_CMH:   rdata = ocr[15:8];
        A_CML:   rdata = ocr[7:0];
        A_CNH:   rdata = cnt[15:8];
        A_CNL:   rdata = cnt[7:0];
        default: rdata = '0;
      endcase
    end
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cnt) |-> $past(tick) && cnt == $past(cnt) + 16'd1); // R1
  AST_MATCH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> flag); // R2
  AST_MATCH_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> cmp_out == $past(lvl)); // R3
  AST_MATCH_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    match && ie && !wr_ctl |=> irq); // R4
  AST_HI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cmh |=> ##1 $stable(cmp_out)); // R5
  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag) |-> $past(wr_cml && armed)); // R7
  AST_COLLIDE: assert property (@(posedge clk) disable iff (!rst_n)
    match && wr_cml && armed |=> flag); // R9
  AST_ONE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> !match ##1 !match ##1 !match); // R10
endmodule

// File: tb/ocmp_timer_tb.sv
module ocmp_timer_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] addr = '0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       cmp_out, irq;
  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  ocmp_timer u_dut (.clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
                    .wdata(wdata), .rdata(rdata), .cmp_out(cmp_out), .irq(irq));

  always #4 clk = ~clk;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) cyc <= 0; else cyc <= cyc + 1;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    addr = a; rd_en = 1'b1; #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [7:0] d);
    addr = a; rd_en = 1'b1; #0.5 d = rdata; rd_en = 1'b0;
  endtask

  task automatic peek16(output logic [15:0] c);
    logic [7:0] h, l;
    peek(3'd4, h); peek(3'd5, l);
    c = {h, l};
  endtask

  task automatic set_target(input int ahead);
    logic [15:0] c, t;
    peek16(c); t = c + 16'(ahead);
    wr(3'd2, t[15:8]); wr(3'd3, t[7:0]);
  endtask

  task automatic t_reset_state();
    logic [7:0] d; logic [15:0] c;
    do_reset();
    check("R8 cmp_out after reset", 16'(cmp_out), 16'd0);
    check("R8 irq after reset", 16'(irq), 16'd0);
    peek(3'd0, d); check("R8 control after reset", 16'(d), 16'h00);
    peek16(c); check("R1 counter reset value", c, 16'hFFFC);
    repeat (4) @(negedge clk);
    peek16(c); check("R1 counter after four clocks", c, 16'hFFFD);
  endtask

  task automatic t_timing();
    logic [15:0] c; logic [7:0] d;
    do_reset();
    wr(3'd0, 8'h41); wr(3'd2, 8'h00); wr(3'd3, 8'h00);
    while (cyc < 16) @(negedge clk);
    peek16(c); check("R1 counter at edge 16", c, 16'h0000);
    check("R2 cmp_out before compare tick", 16'(cmp_out), 16'd0);
    @(negedge clk);
    check("R2 cmp_out after compare tick", 16'(cmp_out), 16'd1);
    check("R4 irq after enabled match", 16'(irq), 16'd1);
    peek(3'd1, d); check("R2 status flag after match", 16'(d), 16'h40);
  endtask

  task automatic t_retain();
    logic [7:0] d;
    wr(3'd2, 8'h12); wr(3'd3, 8'h34);
    do_reset();
    peek(3'd1, d); check("R8 flag kept over reset", 16'(d), 16'h40);
    peek(3'd2, d); check("R8 target high kept", 16'(d), 16'h12);
    peek(3'd3, d); check("R8 target low kept", 16'(d), 16'h34);
    check("R8 cmp_out low after reset", 16'(cmp_out), 16'd0);
  endtask

  task automatic t_collide();
    logic [7:0] d;
    do_reset();
    wr(3'd0, 8'h01); wr(3'd2, 8'h00); wr(3'd3, 8'h00); rd(3'd1, d);
    while (cyc < 16) @(negedge clk);
    wr(3'd3, 8'h00);
    check("R9 match occurred on clear cycle", 16'(cmp_out), 16'd1);
    peek(3'd1, d); check("R9 flag survives collision", 16'(d), 16'h40);
  endtask

  task automatic t_clear();
    logic [7:0] d;
    wr(3'd0, 8'h40);
    check("R4 irq with flag and enable", 16'(irq), 16'd1);
    wr(3'd3, 8'h80);
    peek(3'd1, d); check("R7 unarmed write keeps flag", 16'(d), 16'h40);
    check("R7 irq kept without read", 16'(irq), 16'd1);
    rd(3'd1, d); wr(3'd3, 8'h80);
    peek(3'd1, d); check("R7 flag cleared by handshake", 16'(d), 16'h00);
    check("R7 irq cleared by handshake", 16'(irq), 16'd0);
  endtask

  task automatic t_level();
    logic [7:0] d;
    wr(3'd0, 8'h01); set_target(3); repeat (24) @(negedge clk);
    check("R3 level one on match", 16'(cmp_out), 16'd1);
    peek(3'd1, d); check("R2 flag set", 16'(d), 16'h40);
    wr(3'd0, 8'h00); set_target(3); repeat (24) @(negedge clk);
    check("R3 level zero with flag set", 16'(cmp_out), 16'd0);
    wr(3'd0, 8'h01); set_target(3); repeat (24) @(negedge clk);
    check("R3 level one again", 16'(cmp_out), 16'd1);
  endtask

  task automatic t_irq_en();
    logic [7:0] d; logic [15:0] c;
    wr(3'd0, 8'h00);
    rd(3'd1, d); peek16(c); wr(3'd3, c[7:0] + 8'h80);
    peek(3'd1, d); check("R7 flag cleared before irq test", 16'(d), 16'h00);
    set_target(3); repeat (24) @(negedge clk);
    peek(3'd1, d); check("R4 flag set with irq disabled", 16'(d), 16'h40);
    check("R4 irq low when disabled", 16'(irq), 16'd0);
    wr(3'd0, 8'h40);
    check("R4 irq follows enable", 16'(irq), 16'd1);
  endtask

  task automatic t_hi_inhibit();
    logic [15:0] c, t;
    wr(3'd0, 8'h01);
    peek16(c); t = c + 16'd4;
    wr(3'd2, t[15:8]); wr(3'd3, t[7:0]); wr(3'd2, t[15:8]);
    repeat (30) @(negedge clk);
    check("R5 no match after high write", 16'(cmp_out), 16'd0);
    peek16(c); t = c + 16'd4;
    wr(3'd2, t[15:8]); wr(3'd3, t[7:0]);
    repeat (24) @(negedge clk);
    check("R5 low write resumes compare", 16'(cmp_out), 16'd1);
  endtask

  task automatic t_lo_only();
    logic [15:0] c;
    wr(3'd0, 8'h00);
    peek16(c);
    while (c[7:0] >= 8'hD0) begin
      repeat (16) @(negedge clk);
      peek16(c);
    end
    wr(3'd2, c[15:8]); wr(3'd3, c[7:0] + 8'h40);
    peek16(c); wr(3'd3, c[7:0] + 8'h04);
    repeat (24) @(negedge clk);
    check("R6 low-only write still compares", 16'(cmp_out), 16'd0);
  endtask

  task automatic t_one_match();
    wr(3'd0, 8'h01); set_target(3);
    for (int i = 0; i < 30 && cmp_out == 1'b0; i++) @(negedge clk);
    check("R10 first match seen", 16'(cmp_out), 16'd1);
    wr(3'd0, 8'h00);
    repeat (6) @(negedge clk);
    check("R10 no second match on same value", 16'(cmp_out), 16'd1);
  endtask

  initial begin
    #(8 * 200000);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    t_reset_state();
    t_timing();
    t_retain();
    t_collide();
    t_clear();
    t_level();
    t_irq_en();
    t_hi_inhibit();
    t_lo_only();
    t_one_match();
    finish_run();
  end
endmodule